// File: doc/BRIEF.md
# Retained-SRAM Boot Copy Engine

This block sits in a power domain that stays on while a processor sleeps. It keeps a short bootstrap program in a 256-word local retention array and copies a programmed run of 32-bit words from that array into the processor's instruction memory. The array is kept across processor sleeps and across the block's own reset.

A host programs the block through a plain 32-bit register bus with address, write enable, write data and combinational read data. It loads the bootstrap words into the array window, sets a source word index, a destination word address and a word count, and then either starts a copy at once or arms the block so that every wake event repeats the same copy by itself. The copy drives a single word write port toward instruction memory, one word per clock. When a wake-triggered copy finishes, a one-cycle release pulse lets the processor run.

The block also keeps four general pointer/size words for a host loader. They are stored and read back only, including a load-request flag in bit 31 of the second word.

Top module: `boot_copy_engine`

## Requirements
- R1: After an active-low synchronous reset, every register reads 0, no instruction-memory write is issued and the release output is low. The retention array keeps its contents across that reset.
- R2: Offset 0x004 holds the source word index in bits 7:0. Offset 0x008 holds the destination word address in bits 13:0. Offset 0x00C holds the word count in bits 8:0. Bits above these fields read 0, and an unmapped offset reads 0.
- R3: Offsets 0x090, 0x094, 0x098 and 0x09C are full 32-bit storage words. Setting bit 31 of the word at 0x094 starts no copy.
- R4: Byte offsets 0x400 to 0x7FF form the array window, with word index = offset bits 9:2, for 32-bit reads and writes.
- R5: Writing 1 to control bit 31 (offset 0x000) starts a copy. Bit 31 reads 1 for exactly as many cycles as there are words and then reads 0.
- R6: A copy of N words issues N consecutive one-per-clock writes. Write k carries instruction address dst+k and array word (src+k) mod 256.
- R7: Control bit 30 is an auto-start enable. While it is 1, a wake event on an idle engine starts the same copy. While it is 0, wake events are ignored.
- R8: Bit 0 of the status word (offset 0x010) reads 1 once the latest copy has completed and reads 0 while a new copy runs.
- R9: A start with a word count of 0 issues no write, sets status bit 0 and leaves bit 31 reading 0.
- R10: A start request while a copy runs is ignored. The running copy issues exactly its original count and no second copy follows.
- R11: Host writes to the array window during a copy are refused. Host reads during a copy return the stored word.
- R12: The release output pulses high for one cycle after a wake-triggered copy ends, and never after a host-started copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 12 | Byte offset into the block window |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| wake_evt | input | 1 | Power-up event, one cycle |
| imem_we | output | 1 | Instruction-memory word write enable |
| imem_addr | output | 14 | Instruction-memory word address |
| imem_wdata | output | 32 | Instruction-memory write data |
| cpu_release | output | 1 | One-cycle processor release pulse |

## Verification
The bench targets copies whose source index runs past word 255. A design that failed to wrap would fetch stale or undefined data for the tail words. It issues a second start, changes the count in the middle of a copy, and writes the array while the copy runs. A design that restarted, took the new count or let the write through would issue the wrong number of writes or corrupt the retained program. Zero-length starts are checked for a stray write or a busy bit that sticks. The release pulse is compared between wake-started and host-started copies, since a design that pulsed on both would free the processor too early. A reset in the middle of the sequence checks that registers clear and the array does not.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int HOST_AW = 12;
  localparam int DW      = 32;

  localparam logic [HOST_AW-1:0] OFS_CTRL = 12'h000;
  localparam logic [HOST_AW-1:0] OFS_SRC  = 12'h004;
  localparam logic [HOST_AW-1:0] OFS_DST  = 12'h008;
  localparam logic [HOST_AW-1:0] OFS_CNT  = 12'h00C;
  localparam logic [HOST_AW-1:0] OFS_STAT = 12'h010;
  localparam logic [7:0]         PTR_PAGE = 8'h09;
  localparam int                 N_PTR    = 4;

  localparam int BIT_GO   = 31;
  localparam int BIT_AUTO = 30;

  typedef enum logic {TRIG_HOST = 1'b0, TRIG_WAKE = 1'b1} trig_e;

  // array window: 0x400..0x7FF
  function automatic logic in_array_win(input logic [HOST_AW-1:0] a);
    return a[HOST_AW-1:10] == 2'b01;
  endfunction

  function automatic logic in_ptr_page(input logic [HOST_AW-1:0] a);
    return (a[HOST_AW-1:4] == PTR_PAGE) && (a[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/bce_regs.sv
module bce_regs
  import bce_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int IMEM_AW = 14,
  parameter int CNT_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_we,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  input  logic               busy,
  input  logic               done,
  input  logic [DW-1:0]      arr_rdata,
  output logic [IDX_W-1:0]   cfg_src,
  output logic [IMEM_AW-1:0] cfg_dst,
  output logic [CNT_W-1:0]   cfg_cnt,
  output logic               auto_en,
  output logic               go_req,
  output logic               arr_we_req,
  output logic [IDX_W-1:0]   arr_idx
);
  logic [IDX_W-1:0]   src_q;
  logic [IMEM_AW-1:0] dst_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               auto_q;
  logic [DW-1:0]      ptr_q [N_PTR];

  logic win_hit, ptr_hit;
  assign win_hit    = in_array_win(host_addr);
  assign ptr_hit    = in_ptr_page(host_addr);
  assign arr_idx    = host_addr[IDX_W+1:2];
  assign arr_we_req = host_we && win_hit;
  assign go_req     = host_we && (host_addr == OFS_CTRL) && host_wdata[BIT_GO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      auto_q <= 1'b0;
    end else if (host_we) begin
      if (host_addr == OFS_CTRL) auto_q <= host_wdata[BIT_AUTO];
      if (host_addr == OFS_SRC)  src_q  <= host_wdata[IDX_W-1:0];
      if (host_addr == OFS_DST)  dst_q  <= host_wdata[IMEM_AW-1:0];
      if (host_addr == OFS_CNT)  cnt_q  <= host_wdata[CNT_W-1:0];
    end
  end

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_q[g] <= '0;
      else if (host_we && ptr_hit && (host_addr[3:2] == 2'(g)))
        ptr_q[g] <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (win_hit) begin
      host_rdata = arr_rdata;
    end else if (ptr_hit) begin
      host_rdata = ptr_q[host_addr[3:2]];
    end else begin
      case (host_addr)
        OFS_CTRL: begin
          host_rdata[BIT_GO]   = busy;
          host_rdata[BIT_AUTO] = auto_q;
        end
        OFS_SRC:  host_rdata[IDX_W-1:0]   = src_q;
        OFS_DST:  host_rdata[IMEM_AW-1:0] = dst_q;
        OFS_CNT:  host_rdata[CNT_W-1:0]   = cnt_q;
        OFS_STAT: host_rdata[0]           = done;
        default:  host_rdata = '0;
      endcase
    end
  end

  assign cfg_src = src_q;
  assign cfg_dst = dst_q;
  assign cfg_cnt = cnt_q;
  assign auto_en = auto_q;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we |=> ptr_q[1] == $past(ptr_q[1])) else $error("pointer word changed without a write"); // R3
endmodule

// File: rtl/bce_sram.sv
module bce_sram
  import bce_pkg::*;
#(
  parameter int WORDS = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic [IDX_W-1:0] copy_idx,
  output logic [DW-1:0]    copy_rdata
);
  // retained storage: no reset on purpose
  logic [DW-1:0] mem [WORDS];
  logic          wr_ok;

  assign wr_ok = host_we && !busy;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[host_idx] <= host_wdata;
  end

  assign host_rdata = mem[host_idx];
  assign copy_rdata = mem[copy_idx];

  AST_ARRAY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we) |=> mem[$past(host_idx)] == $past(mem[host_idx]))
    else $error("array written during copy"); // R11
endmodule

// File: rtl/bce_copy_fsm.sv
module bce_copy_fsm
  import bce_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int IMEM_AW = 14,
  parameter int CNT_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_req,
  input  logic               wake_evt,
  input  logic               auto_en,
  input  logic [IDX_W-1:0]   cfg_src,
  input  logic [IMEM_AW-1:0] cfg_dst,
  input  logic [CNT_W-1:0]   cfg_cnt,
  input  logic [DW-1:0]      copy_rdata,
  output logic [IDX_W-1:0]   copy_idx,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [DW-1:0]      imem_wdata,
  output logic               busy,
  output logic               done,
  output logic               cpu_release
);
  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return i + 1'b1;  // wraps inside the array
  endfunction

  function automatic logic [IMEM_AW-1:0] next_dst(input logic [IMEM_AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic [IDX_W-1:0]   src_q;
  logic [IMEM_AW-1:0] dst_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q, done_q, rel_q;
  trig_e              trig_q;

  // named internal events
  logic host_launch, wake_launch, launch, cnt_zero, finish;
  assign host_launch = go_req && !busy_q;
  assign wake_launch = wake_evt && auto_en && !busy_q && !host_launch;
  assign launch      = host_launch || wake_launch;
  assign cnt_zero    = (cfg_cnt == '0);
  assign finish      = busy_q && (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rel_q  <= 1'b0;
      trig_q <= TRIG_HOST;
    end else begin
      rel_q <= 1'b0;
      if (launch) begin
        trig_q <= wake_launch ? TRIG_WAKE : TRIG_HOST;
        if (cnt_zero) begin
          done_q <= 1'b1;
          rel_q  <= wake_launch;
        end else begin
          busy_q <= 1'b1;
          done_q <= 1'b0;
          src_q  <= cfg_src;
          dst_q  <= cfg_dst;
          left_q <= cfg_cnt;
        end
      end else if (busy_q) begin
        src_q  <= next_idx(src_q);
        dst_q  <= next_dst(dst_q);
        left_q <= left_q - 1'b1;
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rel_q  <= (trig_q == TRIG_WAKE);
        end
      end
    end
  end

  assign copy_idx    = src_q;
  assign imem_we     = busy_q;
  assign imem_addr   = dst_q;
  assign imem_wdata  = copy_rdata;
  assign busy        = busy_q;
  assign done        = done_q;
  assign cpu_release = rel_q;

  AST_WORD_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish) |=> (imem_we && imem_addr == $past(imem_addr) + 1'b1))
    else $error("destination did not step"); // R6
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !finish) |=> copy_idx == $past(copy_idx) + 1'b1)
    else $error("source did not step"); // R6
  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy))
    else $error("done missing after copy"); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done)
    else $error("done still set in new copy"); // R8
  AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && cnt_zero) |=> (!imem_we && done))
    else $error("zero count wrote"); // R9
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && go_req && !finish) |=> left_q == $past(left_q) - 1'b1)
    else $error("start during copy reloaded"); // R10
  AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_release && !wake_evt) |=> !cpu_release)
    else $error("release longer than one cycle"); // R12
  AST_RELEASE_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release |-> (done && trig_q == TRIG_WAKE))
    else $error("release after host copy"); // R12
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
  import bce_pkg::*;
#(
  parameter int SRAM_WORDS = 256,
  parameter int IMEM_AW    = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        host_addr,
  input  logic               host_we,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               wake_evt,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [31:0]        imem_wdata,
  output logic               cpu_release
);
  localparam int IDX_W = $clog2(SRAM_WORDS);
  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0]   cfg_src, arr_idx, copy_idx;
  logic [IMEM_AW-1:0] cfg_dst;
  logic [CNT_W-1:0]   cfg_cnt;
  logic               auto_en, go_req, arr_we_req, busy, done;
  logic [DW-1:0]      arr_rdata, copy_rdata;

  bce_regs #(.IDX_W(IDX_W), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy(busy), .done(done), .arr_rdata(arr_rdata),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .auto_en(auto_en), .go_req(go_req),
    .arr_we_req(arr_we_req), .arr_idx(arr_idx)
  );

  bce_sram #(.WORDS(SRAM_WORDS), .IDX_W(IDX_W)) u_sram (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .host_we(arr_we_req), .host_idx(arr_idx), .host_wdata(host_wdata),
    .host_rdata(arr_rdata),
    .copy_idx(copy_idx), .copy_rdata(copy_rdata)
  );

  bce_copy_fsm #(.IDX_W(IDX_W), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .go_req(go_req), .wake_evt(wake_evt), .auto_en(auto_en),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .copy_rdata(copy_rdata), .copy_idx(copy_idx),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .busy(busy), .done(done), .cpu_release(cpu_release)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> (!imem_we && !cpu_release))
    else $error("activity right after reset"); // R1
endmodule

// File: tb/test_boot_copy_engine.sv
`timescale 1ns/1ps
module test_boot_copy_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] host_addr = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        wake_evt = 1'b0;
  logic        imem_we;
  logic [13:0] imem_addr;
  logic [31:0] imem_wdata;
  logic        cpu_release;

  always #4 clk = ~clk;  // 125 MHz

  boot_copy_engine i_boot_copy_engine (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .wake_evt(wake_evt),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .cpu_release(cpu_release)
  );

  int n_checks = 0;
  int n_fail = 0;
  int n_writes = 0;
  int n_rel = 0;
  logic [31:0] imem_seen [int];

  typedef struct packed {
    logic [11:0] addr;
    logic        wr;
    logic [31:0] data;  // write data, or expected read data
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{12'h004, 1'b1, 32'hFFFF_FF12}, '{12'h004, 1'b0, 32'h0000_0012},
    '{12'h008, 1'b1, 32'hFFFF_1234}, '{12'h008, 1'b0, 32'h0000_1234},
    '{12'h00C, 1'b1, 32'hFFFF_FFFF}, '{12'h00C, 1'b0, 32'h0000_01FF},
    '{12'h090, 1'b1, 32'hDEAD_BEEF}, '{12'h094, 1'b1, 32'h8000_0010},
    '{12'h098, 1'b1, 32'h0BAD_F00D}, '{12'h09C, 1'b1, 32'h1234_5678},
    '{12'h090, 1'b0, 32'hDEAD_BEEF}, '{12'h094, 1'b0, 32'h8000_0010},
    '{12'h09C, 1'b0, 32'h1234_5678}, '{12'h400, 1'b1, 32'hA5A5_0001},
    '{12'h7FC, 1'b1, 32'h5A5A_00FF}, '{12'h400, 1'b0, 32'hA5A5_0001},
    '{12'h7FC, 1'b0, 32'h5A5A_00FF}, '{12'h020, 1'b0, 32'h0000_0000},
    '{12'h000, 1'b0, 32'h0000_0000}, '{12'h010, 1'b0, 32'h0000_0000}
  };

  function automatic logic [31:0] pattern(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {16'hB007, b, ~b};
  endfunction

  function automatic string tag_for(input logic [11:0] a);
    if (a >= 12'h400) return "R4";
    if (a[11:4] == 8'h09) return "R3";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // observe outputs away from the rising edge
  always @(negedge clk) begin
    if (rst_n && imem_we) begin
      imem_seen[int'(imem_addr)] = imem_wdata;
      n_writes++;
    end
    if (rst_n && cpu_release) n_rel++;
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_we = 1'b0;
    #1 d = host_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_we = 1'b0;
    end
  endtask

  // polls control bit 31; returns the number of reads that saw it set
  task automatic wait_idle(output int busy_reads);
    logic [31:0] d;
    busy_reads = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(12'h000, d);
      if (!d[31]) break;
      busy_reads++;
    end
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    host_we = 1'b0; wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  task automatic setup(input int src, input int dst, input int cnt);
    wr(12'h004, 32'(src));
    wr(12'h008, 32'(dst));
    wr(12'h00C, 32'(cnt));
    idle(1);
    n_writes = 0;
    n_rel = 0;
    imem_seen.delete();
  endtask

  task automatic check_image(input string req, input int src, input int dst, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      logic [31:0] got;
      int da;
      da = (dst + k) & 16'h3FFF;
      got = imem_seen.exists(da) ? imem_seen[da] : 32'hXXXX_XXXX;
      check(got === pattern((src + k) % 256), req, got, pattern((src + k) % 256));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int br;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(12'h000, d); check(d == 32'h0, "R1 ctrl", d, 32'h0);
    rd(12'h010, d); check(d == 32'h0, "R1 status", d, 32'h0);
    rd(12'h004, d); check(d == 32'h0, "R1 src", d, 32'h0);
    check({imem_we, cpu_release} == 2'b00, "R1 outputs", {30'd0, imem_we, cpu_release}, 32'h0);

    // R2 R3 R4: register and window table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].wr) begin
        wr(VEC[v].addr, VEC[v].data);
      end else begin
        rd(VEC[v].addr, d);
        check(d == VEC[v].data, tag_for(VEC[v].addr), d, VEC[v].data);
      end
    end
    idle(3);
    check(n_writes == 0, "R3 load flag inert", 32'(n_writes), 32'd0);

    // fill the retention array
    for (int i = 0; i < 256; i++) wr(12'h400 + 12'(i * 4), pattern(i));
    idle(1);

    // R5 R6 R8: host copy of 8 words
    setup(4, 32'h100, 8);
    wr(12'h000, 32'h8000_0000);
    rd(12'h010, d); check(d == 32'h0, "R8 done clears at start", d, 32'h0);
    wait_idle(br);
    check(br == 7, "R5 busy readback cycles", 32'(br), 32'd7);
    check(n_writes == 8, "R6 write count", 32'(n_writes), 32'd8);
    check_image("R6 image", 4, 32'h100, 8);
    rd(12'h010, d); check(d == 32'h1, "R8 done", d, 32'h1);
    check(n_rel == 0, "R12 no release on host copy", 32'(n_rel), 32'd0);

    // R6: source wrap past word 255
    setup(250, 32'h200, 10);
    wr(12'h000, 32'h8000_0000);
    wait_idle(br);
    check(n_writes == 10, "R6 wrap count", 32'(n_writes), 32'd10);
    check_image("R6 wrap image", 250, 32'h200, 10);

    // R9: zero-length copy
    setup(0, 32'h300, 0);
    wr(12'h000, 32'h8000_0000);
    rd(12'h000, d); check(d[31] == 1'b0, "R9 start bit", d, 32'h0);
    rd(12'h010, d); check(d == 32'h1, "R9 done", d, 32'h1);
    idle(2);
    check(n_writes == 0, "R9 no write", 32'(n_writes), 32'd0);

    // R10: second start and new count during a copy
    setup(0, 32'h300, 6);
    wr(12'h000, 32'h8000_0000);
    wr(12'h00C, 32'd3);
    wr(12'h000, 32'h8000_0000);
    wait_idle(br);
    idle(5);
    check(n_writes == 6, "R10 restart ignored", 32'(n_writes), 32'd6);
    check_image("R10 image", 0, 32'h300, 6);

    // R11: array write refused during copy
    setup(0, 32'h400, 20);
    wr(12'h000, 32'h8000_0000);
    wr(12'h400 + 12'(100 * 4), 32'hFFFF_FFFF);
    rd(12'h400 + 12'(100 * 4), d);
    check(d == pattern(100), "R11 read during copy", d, pattern(100));
    wait_idle(br);
    rd(12'h400 + 12'(100 * 4), d);
    check(d == pattern(100), "R11 write refused", d, pattern(100));

    // R7 R12: wake-triggered copy
    wr(12'h000, 32'h4000_0000);
    rd(12'h000, d); check(d == 32'h4000_0000, "R7 auto bit", d, 32'h4000_0000);
    setup(16, 32'h500, 4);
    pulse_wake();
    wait_idle(br);
    idle(3);
    check(n_writes == 4, "R7 wake copy count", 32'(n_writes), 32'd4);
    check_image("R7 wake image", 16, 32'h500, 4);
    check(n_rel == 1, "R12 single release", 32'(n_rel), 32'd1);
    rd(12'h000, d); check(d == 32'h4000_0000, "R7 auto stays armed", d, 32'h4000_0000);

    // R7: wake ignored while disarmed
    wr(12'h000, 32'h0);
    setup(16, 32'h600, 4);
    pulse_wake();
    idle(10);
    check(n_writes == 0, "R7 wake ignored", 32'(n_writes), 32'd0);
    check(n_rel == 0, "R12 no release when disarmed", 32'(n_rel), 32'd0);

    // R1: reset clears registers but keeps the array
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(12'h004, d); check(d == 32'h0, "R1 src after reset", d, 32'h0);
    rd(12'h094, d); check(d == 32'h0, "R1 pointer after reset", d, 32'h0);
    rd(12'h010, d); check(d == 32'h0, "R1 status after reset", d, 32'h0);
    rd(12'h400 + 12'(5 * 4), d); check(d == pattern(5), "R1 array retained", d, pattern(5));

    idle(2);
    finish_run();
  end
endmodule